// File: doc/BRIEF.md
# Hysteresis Switch and Interrupt Unit

This block sits behind the sampling path of a three-axis field sensor. It takes each completed measurement, one signed sample per axis, and compares it against two programmable threshold pairs per axis. That makes six comparators in total. Each pair has an operate level and a release level. Each comparator keeps a switch bit with hysteresis: the bit sets above the operate level, clears below the release level, and otherwise holds its value. The block also keeps the measurement status flags: a data-ready flag, a data-overrun flag, the XY sensor-overflow flag and the ADC-overflow flag. It packs all of these into one status word.

Each enabled event source drives a small interrupt state machine. The state machine feeds two pins: a push-pull line that is active high, and an open-drain line that is active low. The open-drain line is modelled as an output enable, with its data line tied low. The register interface reports accesses through a level signal with an address and a direction. While the host reads the measurement range or writes the settings range, both interrupt pins are held inactive. An event that arrives during such an access is shown on the pins once the access ends.

The interrupt state machine has four states. In IRQ_IDLE no interrupt is shown. IRQ_FIRED drives the enabled pins. IRQ_MASKED means a blanking access is in progress and nothing is pending. IRQ_MASKED_PEND means a blanking access is in progress and an event is waiting. The transitions are:
- **idle-to-fired**: an event with no access.
- **idle/fired-to-masked**: access without an event.
- **idle/fired/masked-to-pend**: an event during an access.
- **masked-to-idle**: the access ends.
- **masked-to-fired**: the access ends together with a new event.
- **pend-to-fired**: the access ends.

IRQ_FIRED holds until a blanking access arrives.

Top module: `hyst_switch_irq`

## Requirements
- R1: A comparator is armed only when its operate level is greater than its release level, comparing both as signed two's complement. When armed, a sample strictly above the operate level sets the switch bit to 1 and a sample strictly below the release level clears it to 0. Comparator index i = axis*SETS_PER_AXIS + set, where axis 0 is X, 1 is Y and 2 is Z, in the low-to-high slices of `smp_data`.
- R2: A switch bit holds its value when the sample lies inside the band, when its comparator is not armed, and in every cycle without `smp_valid`.
- R3: On a strobe, a change of a switch bit in either direction is an interrupt event when its `sw_en` bit is set. A change of a bit whose enable is clear is no event.
- R4: Data ready (status bit 0) sets on every `smp_valid`. With `drdy_en` set, every measurement is an interrupt event.
- R5: Data ready clears on `data_read_done`, and on any read or write access to the settings range 20h–27h. A measurement in the same cycle as a clear leaves it set. Accesses outside that range do not clear it.
- R6: On each `smp_valid`, data overrun (bit 9) takes the value `cont_mode` AND the data-ready flag before that measurement. Outside continuous mode it is therefore cleared. It changes only on a measurement.
- R7: XY overflow (bit 7) and ADC overflow (bit 8) copy `err_xy_in` and `err_adc_in` on every `smp_valid`. An input that is high on a strobe is an event only when its own enable is set.
- R8: Status bits 6 down to 1 hold the switch bits in comparator order (X set 1, X set 2, Y set 1, Y set 2, Z set 1, Z set 2). Bits 15:10 always read 1. The reset value is FC00h.
- R9: In IRQ_FIRED, `irq_pp` is 1 if `pp_en` is set and `irq_od_oe` is 1 if `od_en` is set. A disabled pin stays inactive, and `irq_od_dat` is always 0.
- R10: A read access to 10h–1Fh or a write access to 20h–27h forces both pins inactive from the next cycle for as long as it lasts. Writes to 10h–1Fh and reads of 20h–27h do not blank the pins.
- R11: A fired interrupt stays active with no further events until a blanking access. An event during a blanking access appears on the pins in the cycle after the access ends.
- R12: A synchronous active-low reset clears every switch bit and flag and leaves both pins inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a measurement has completed |
| smp_data | input | NUM_AXES*DATA_W | Signed samples; X in the lowest slice |
| err_xy_in | input | 1 | XY sensor overflow seen in this measurement |
| err_adc_in | input | 1 | ADC overflow seen in this measurement |
| cont_mode | input | 1 | Continuous measurement mode is selected |
| op_lvl | input | NSW*DATA_W | Operate levels, one slice per comparator |
| rel_lvl | input | NSW*DATA_W | Release levels, one slice per comparator |
| sw_en | input | NSW | Per-comparator switch event enable |
| drdy_en | input | 1 | Data-ready event enable |
| errxy_en | input | 1 | XY overflow event enable |
| erradc_en | input | 1 | ADC overflow event enable |
| pp_en | input | 1 | Push-pull interrupt pin enable |
| od_en | input | 1 | Open-drain interrupt pin enable |
| acc_active | input | 1 | Register access in progress (level) |
| acc_write | input | 1 | Access direction: 1 for write |
| acc_addr | input | ADDR_W | Address of the access |
| data_read_done | input | 1 | Pulse: a measurement data register was fully read |
| status | output | STAT_W | Status word |
| irq_pp | output | 1 | Push-pull interrupt, active high |
| irq_od_oe | output | 1 | Open-drain pull-down enable (pin active low) |
| irq_od_dat | output | 1 | Open-drain data, held at 0 |

## Verification
The bench builds the block with DATA_W set to 4 and every other parameter at its default. This shrinks each sample and threshold to sixteen values. With that width, the bench can sweep every operate level, every release level, every sample and both prior switch states across all six comparators. That covers armed and unarmed pairs, the exact-equality edges of the band, and the wrap at the signed extremes. After each step it checks the switch bits and the toggle interrupt. Directed sequences then cover the flag timing, the blanking address windows, and the events held pending during an access.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE        = 2'd0,
        IRQ_FIRED       = 2'd1,
        IRQ_MASKED      = 2'd2,
        IRQ_MASKED_PEND = 2'd3
    } irq_state_t;

endpackage

// File: rtl/hsw_comparator.sv
module hsw_comparator #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] op,
    input  logic [W-1:0] rel,
    output logic         sw,
    output logic         toggle
);

    logic armed;
    logic sw_nxt;

    // A pair only acts when operate sits above release.
    assign armed = $signed(op) > $signed(rel);

    always_comb begin
        sw_nxt = sw;
        if (armed) begin
            if ($signed(sample) > $signed(op)) begin
                sw_nxt = 1'b1;
            end else if ($signed(sample) < $signed(rel)) begin
                sw_nxt = 1'b0;
            end
        end
    end

    assign toggle = strobe & (sw_nxt != sw);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw <= 1'b0;
        end else if (strobe) begin
            sw <= sw_nxt;
        end
    end

endmodule

// File: rtl/hsw_status_flags.sv
module hsw_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic err_xy,
    input  logic err_adc,
    input  logic cont_mode,
    input  logic rd_done,
    input  logic set_acc,
    output logic drdy,
    output logic dor,
    output logic errxy,
    output logic erradc
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy   <= 1'b0;
            dor    <= 1'b0;
            errxy  <= 1'b0;
            erradc <= 1'b0;
        end else begin
            // A fresh measurement outranks a clear in the same cycle.
            if (strobe) begin
                drdy <= 1'b1;
            end else if (rd_done || set_acc) begin
                drdy <= 1'b0;
            end
            if (strobe) begin
                dor    <= cont_mode & drdy;
                errxy  <= err_xy;
                erradc <= err_adc;
            end
        end
    end

endmodule

// File: rtl/hsw_irq_fsm.sv
module hsw_irq_fsm
    import hsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic blank,
    output logic fired
);

    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE, IRQ_FIRED: begin
                if (blank) begin
                    state_d = evt ? IRQ_MASKED_PEND : IRQ_MASKED;
                end else if (evt) begin
                    state_d = IRQ_FIRED;
                end
            end
            IRQ_MASKED: begin
                if (blank) begin
                    state_d = evt ? IRQ_MASKED_PEND : IRQ_MASKED;
                end else begin
                    state_d = evt ? IRQ_FIRED : IRQ_IDLE;
                end
            end
            IRQ_MASKED_PEND: begin
                if (!blank) begin
                    state_d = IRQ_FIRED;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        fired = (state_q == IRQ_FIRED);
    end

endmodule

// File: rtl/hyst_switch_irq.sv
module hyst_switch_irq #(
    parameter int DATA_W        = 16,
    parameter int NUM_AXES      = 3,
    parameter int SETS_PER_AXIS = 2,
    parameter int ADDR_W        = 7,
    parameter int STAT_W        = 16,
    parameter int RD_LO         = 'h10,
    parameter int RD_HI         = 'h1F,
    parameter int WR_LO         = 'h20,
    parameter int WR_HI         = 'h27
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      smp_valid,
    input  logic [NUM_AXES*DATA_W-1:0]                smp_data,
    input  logic                                      err_xy_in,
    input  logic                                      err_adc_in,
    input  logic                                      cont_mode,
    input  logic [NUM_AXES*SETS_PER_AXIS*DATA_W-1:0]  op_lvl,
    input  logic [NUM_AXES*SETS_PER_AXIS*DATA_W-1:0]  rel_lvl,
    input  logic [NUM_AXES*SETS_PER_AXIS-1:0]         sw_en,
    input  logic                                      drdy_en,
    input  logic                                      errxy_en,
    input  logic                                      erradc_en,
    input  logic                                      pp_en,
    input  logic                                      od_en,
    input  logic                                      acc_active,
    input  logic                                      acc_write,
    input  logic [ADDR_W-1:0]                         acc_addr,
    input  logic                                      data_read_done,
    output logic [STAT_W-1:0]                         status,
    output logic                                      irq_pp,
    output logic                                      irq_od_oe,
    output logic                                      irq_od_dat
);

    localparam int NSW    = NUM_AXES * SETS_PER_AXIS;
    localparam int FLAG_W = NSW + 4;
    localparam int PAD_W  = STAT_W - FLAG_W;

    localparam logic [ADDR_W-1:0] RD_LO_A = ADDR_W'(RD_LO);
    localparam logic [ADDR_W-1:0] RD_HI_A = ADDR_W'(RD_HI);
    localparam logic [ADDR_W-1:0] WR_LO_A = ADDR_W'(WR_LO);
    localparam logic [ADDR_W-1:0] WR_HI_A = ADDR_W'(WR_HI);

    logic [NSW-1:0] sw_q;
    logic [NSW-1:0] sw_tgl;
    logic           drdy, dor, errxy, erradc;
    logic           in_rd_win, in_set_win;
    logic           blank, set_acc;
    logic           evt;
    logic           fired;

    // Address window decode for blanking and settings access.
    assign in_rd_win  = (acc_addr >= RD_LO_A) && (acc_addr <= RD_HI_A);
    assign in_set_win = (acc_addr >= WR_LO_A) && (acc_addr <= WR_HI_A);
    assign blank      = acc_active && ((!acc_write && in_rd_win) ||
                                       (acc_write && in_set_win));
    assign set_acc    = acc_active && in_set_win;

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        localparam int AX = i / SETS_PER_AXIS;
        hsw_comparator #(.W(DATA_W)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (smp_valid),
            .sample (smp_data[AX*DATA_W +: DATA_W]),
            .op     (op_lvl[i*DATA_W +: DATA_W]),
            .rel    (rel_lvl[i*DATA_W +: DATA_W]),
            .sw     (sw_q[i]),
            .toggle (sw_tgl[i])
        );
    end

    hsw_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (smp_valid),
        .err_xy    (err_xy_in),
        .err_adc   (err_adc_in),
        .cont_mode (cont_mode),
        .rd_done   (data_read_done),
        .set_acc   (set_acc),
        .drdy      (drdy),
        .dor       (dor),
        .errxy     (errxy),
        .erradc    (erradc)
    );

    assign evt = smp_valid & (drdy_en |
                              (errxy_en & err_xy_in) |
                              (erradc_en & err_adc_in) |
                              (|(sw_tgl & sw_en)));

    hsw_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .blank (blank),
        .fired (fired)
    );

    assign irq_pp     = fired & pp_en;
    assign irq_od_oe  = fired & od_en;
    assign irq_od_dat = 1'b0;

    if (PAD_W > 0) begin : g_pad
        assign status = {{PAD_W{1'b1}}, dor, erradc, errxy, sw_q, drdy};
    end else begin : g_nopad
        assign status = {dor, erradc, errxy, sw_q, drdy};
    end

endmodule

// File: rtl/hyst_switch_irq_chk.sv
module hyst_switch_irq_chk #(
    parameter int DATA_W        = 16,
    parameter int NUM_AXES      = 3,
    parameter int SETS_PER_AXIS = 2,
    parameter int ADDR_W        = 7,
    parameter int STAT_W        = 16,
    parameter int RD_LO         = 'h10,
    parameter int RD_HI         = 'h1F,
    parameter int WR_LO         = 'h20,
    parameter int WR_HI         = 'h27
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     smp_valid,
    input logic [NUM_AXES*DATA_W-1:0]               smp_data,
    input logic                                     cont_mode,
    input logic [NUM_AXES*SETS_PER_AXIS*DATA_W-1:0] op_lvl,
    input logic [NUM_AXES*SETS_PER_AXIS*DATA_W-1:0] rel_lvl,
    input logic                                     pp_en,
    input logic                                     acc_active,
    input logic                                     acc_write,
    input logic [ADDR_W-1:0]                        acc_addr,
    input logic [STAT_W-1:0]                        status,
    input logic                                     irq_pp,
    input logic                                     irq_od_oe
);

    localparam int NSW     = NUM_AXES * SETS_PER_AXIS;
    localparam int DOR_BIT = NSW + 3;

    logic signed [DATA_W-1:0] s0, op0, rel0;
    logic quiet_access;
    logic band0;

    assign s0   = $signed(smp_data[DATA_W-1:0]);
    assign op0  = $signed(op_lvl[DATA_W-1:0]);
    assign rel0 = $signed(rel_lvl[DATA_W-1:0]);
    assign band0 = !(op0 > rel0) || ((s0 <= op0) && (s0 >= rel0));

    assign quiet_access = acc_active &&
        ((!acc_write && acc_addr >= ADDR_W'(RD_LO) && acc_addr <= ADDR_W'(RD_HI)) ||
         ( acc_write && acc_addr >= ADDR_W'(WR_LO) && acc_addr <= ADDR_W'(WR_HI)));

    assert_band_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && band0) |=> $stable(status[1]));

    assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(status[NSW:1]));

    assert_drdy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> status[0]);

    assert_no_overrun_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cont_mode) |=> !status[DOR_BIT]);

    assert_pp_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_en |-> !irq_pp);

    assert_blank_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_access |=> (!irq_pp && !irq_od_oe));

endmodule

bind hyst_switch_irq hyst_switch_irq_chk #(
    .DATA_W(DATA_W), .NUM_AXES(NUM_AXES), .SETS_PER_AXIS(SETS_PER_AXIS),
    .ADDR_W(ADDR_W), .STAT_W(STAT_W), .RD_LO(RD_LO), .RD_HI(RD_HI),
    .WR_LO(WR_LO), .WR_HI(WR_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cont_mode(cont_mode), .op_lvl(op_lvl), .rel_lvl(rel_lvl), .pp_en(pp_en),
    .acc_active(acc_active), .acc_write(acc_write), .acc_addr(acc_addr),
    .status(status), .irq_pp(irq_pp), .irq_od_oe(irq_od_oe)
);

// File: tb/sim_hyst_switch_irq.sv
module sim_hyst_switch_irq;

    localparam int DW  = 4;
    localparam int NA  = 3;
    localparam int NS  = 2;
    localparam int NSW = NA * NS;
    localparam int AW  = 7;
    localparam int SW  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              smp_valid;
    logic [NA*DW-1:0]  smp_data;
    logic              err_xy_in, err_adc_in, cont_mode;
    logic [NSW*DW-1:0] op_lvl, rel_lvl;
    logic [NSW-1:0]    sw_en;
    logic              drdy_en, errxy_en, erradc_en, pp_en, od_en;
    logic              acc_active, acc_write;
    logic [AW-1:0]     acc_addr;
    logic              data_read_done;
    logic [SW-1:0]     status;
    logic              irq_pp, irq_od_oe, irq_od_dat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    hyst_switch_irq #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .err_xy_in(err_xy_in), .err_adc_in(err_adc_in), .cont_mode(cont_mode),
        .op_lvl(op_lvl), .rel_lvl(rel_lvl), .sw_en(sw_en), .drdy_en(drdy_en),
        .errxy_en(errxy_en), .erradc_en(erradc_en), .pp_en(pp_en), .od_en(od_en),
        .acc_active(acc_active), .acc_write(acc_write), .acc_addr(acc_addr),
        .data_read_done(data_read_done), .status(status), .irq_pp(irq_pp),
        .irq_od_oe(irq_od_oe), .irq_od_dat(irq_od_dat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe();
        smp_valid = 1'b1;
        step();
        smp_valid = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a);
        acc_active = 1'b1;
        acc_write  = wr;
        acc_addr   = a;
        step();
        acc_active = 1'b0;
    endtask

    task automatic read_done();
        data_read_done = 1'b1;
        step();
        data_read_done = 1'b0;
    endtask

    task automatic set_samples(input int x, input int y, input int z);
        smp_data = {DW'(z), DW'(y), DW'(x)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        err_xy_in = 1'b0; err_adc_in = 1'b0; cont_mode = 1'b0;
        op_lvl = '0; rel_lvl = '0; sw_en = '0;
        drdy_en = 1'b0; errxy_en = 1'b0; erradc_en = 1'b0;
        pp_en = 1'b0; od_en = 1'b0;
        acc_active = 1'b0; acc_write = 1'b0; acc_addr = '0;
        data_read_done = 1'b0;
        repeat (3) step();
        chk("R12 reset status", status, 32'hFC00);
        chk("R8 reset pad ones", status[15:10], 32'h3F);
        chk("R12 reset irq_pp", irq_pp, 0);
        chk("R12 reset irq_od_oe", irq_od_oe, 0);
        chk("R9 od data low", irq_od_dat, 0);
        rst_n = 1'b1;
        step();

        // Data ready and its clears
        op_lvl = {NSW{DW'(3)}}; rel_lvl = {NSW{DW'(-3)}}; set_samples(0, 0, 0);
        strobe();
        chk("R4 drdy set", status, 32'hFC01);
        read_done();
        chk("R5 clear by read done", status, 32'hFC00);
        strobe(); access(1'b1, 7'h22);
        chk("R5 clear by settings write", status, 32'hFC00);
        strobe(); access(1'b0, 7'h25);
        chk("R5 clear by settings read", status, 32'hFC00);
        strobe(); access(1'b0, 7'h30);
        chk("R5 other access keeps drdy", status, 32'hFC01);
        read_done();
        smp_valid = 1'b1; data_read_done = 1'b1; step();
        smp_valid = 1'b0; data_read_done = 1'b0;
        chk("R5 measurement wins over clear", status, 32'hFC01);
        read_done();

        // Data overrun
        cont_mode = 1'b1;
        strobe();
        chk("R6 first sample no overrun", status, 32'hFC01);
        strobe();
        chk("R6 overrun on unread data", status, 32'hFE01);
        read_done();
        chk("R6 overrun held over read", status, 32'hFE00);
        strobe();
        chk("R6 overrun clears next sample", status, 32'hFC01);
        cont_mode = 1'b0;
        strobe();
        chk("R6 single mode no overrun", status, 32'hFC01);
        read_done();

        // Overflow flags
        err_xy_in = 1'b1; strobe();
        chk("R7 xy flag", status, 32'hFC81);
        err_xy_in = 1'b0; err_adc_in = 1'b1; strobe();
        chk("R7 adc flag refreshed", status, 32'hFD01);
        err_adc_in = 1'b0; strobe();
        chk("R7 flags cleared by refresh", status, 32'hFC01);
        read_done();

        // Pin enables and overflow events
        errxy_en = 1'b1; pp_en = 1'b1; od_en = 1'b0; err_xy_in = 1'b1;
        strobe();
        chk("R7 xy event pp", irq_pp, 1);
        chk("R9 od disabled", irq_od_oe, 0);
        access(1'b0, 7'h10);
        chk("R10 read blank", irq_pp, 0);
        od_en = 1'b1; pp_en = 1'b0;
        strobe();
        chk("R9 od enabled", irq_od_oe, 1);
        chk("R9 pp disabled", irq_pp, 0);
        chk("R9 od data low", irq_od_dat, 0);
        access(1'b0, 7'h1F);
        err_xy_in = 1'b0; err_adc_in = 1'b1; erradc_en = 1'b0; pp_en = 1'b1;
        strobe();
        chk("R7 adc without enable", irq_pp, 0);
        err_adc_in = 1'b0; errxy_en = 1'b0;
        strobe();
        read_done();

        // Hold and blanking windows
        drdy_en = 1'b1;
        strobe();
        chk("R4 drdy event", irq_pp, 1);
        drdy_en = 1'b0;
        repeat (3) step();
        chk("R11 held while idle", irq_pp, 1);
        access(1'b1, 7'h10);
        chk("R10 write low window no blank", irq_pp, 1);
        access(1'b0, 7'h22);
        chk("R10 settings read no blank", irq_pp, 1);
        access(1'b1, 7'h27);
        chk("R10 settings write blank", irq_pp, 0);
        chk("R10 settings write blank od", irq_od_oe, 0);
        step();
        chk("R10 stays idle after access", irq_pp, 0);

        // Event during access
        drdy_en = 1'b1;
        acc_active = 1'b1; acc_write = 1'b0; acc_addr = 7'h12;
        smp_valid = 1'b1; step(); smp_valid = 1'b0;
        chk("R11 blank during access", irq_pp, 0);
        step();
        chk("R11 still blank", irq_pp, 0);
        acc_active = 1'b0; step();
        chk("R11 pending shown after access", irq_pp, 1);
        access(1'b0, 7'h10);
        drdy_en = 1'b0;
        read_done();

        // Switch mapping and toggle events
        op_lvl = {NSW{DW'(2)}}; op_lvl[1*DW +: DW] = DW'(6);
        rel_lvl = {NSW{DW'(-2)}};
        sw_en = 6'b000001;
        set_samples(5, 0, 0); strobe();
        chk("R1 X1 set only", status[6:1], 32'h01);
        chk("R3 enabled toggle event", irq_pp, 1);
        access(1'b0, 7'h10);
        set_samples(5, 5, 5); strobe();
        chk("R8 switch bit order", status[6:1], 32'h3D);
        chk("R3 disabled toggles no event", irq_pp, 0);
        set_samples(-5, -5, -5); strobe();
        chk("R1 clear below release", status[6:1], 32'h00);
        chk("R3 falling toggle event", irq_pp, 1);
        access(1'b0, 7'h10);
        op_lvl = {NSW{DW'(-2)}}; rel_lvl = {NSW{DW'(2)}};
        set_samples(7, 7, 7); strobe();
        chk("R1 unarmed pair holds", status[6:1], 32'h00);
        read_done();

        // Exhaustive sweep of thresholds, samples and prior state
        sw_en = '1; pp_en = 1'b1; od_en = 1'b1;
        for (int op = -8; op < 8; op++) begin
            for (int rel = -8; rel < 8; rel++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int s = -8; s < 8; s++) begin
                        int expv;
                        op_lvl = {NSW{DW'(1)}}; rel_lvl = {NSW{DW'(0)}};
                        if (p == 1) set_samples(7, 7, 7);
                        else        set_samples(-8, -8, -8);
                        strobe();
                        access(1'b0, 7'h10);
                        op_lvl = {NSW{DW'(op)}}; rel_lvl = {NSW{DW'(rel)}};
                        set_samples(s, s, s);
                        strobe();
                        expv = p;
                        if (op > rel) begin
                            if (s > op)       expv = 1;
                            else if (s < rel) expv = 0;
                        end
                        chk((op > rel) ? "R1 sweep switch" : "R2 sweep switch",
                            status[6:1], expv ? 32'h3F : 32'h00);
                        chk("R3 sweep toggle irq", {irq_pp, irq_od_oe},
                            (expv != p) ? 32'h3 : 32'h0);
                    end
                end
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule